// File: doc/BRIEF.md
# Three-Stage Phase-Aligned Clock-Enable Prescaler

This block divides a single fast clock into three slower rates for the CPU and peripheral domains. It does not make new clocks. Each rate is a one-cycle enable pulse on the input clock, so all downstream logic stays in one clock domain.

Three stages are cascaded. The first stage divides by a power of two from 1 to 512. The second stage divides its input again by 1, 2 or 4. The third stage divides again by 1 or 2. The overall ratio is capped at 2048. All three pulse trains come from one shared phase counter, so a slower pulse always falls on a cycle where every faster pulse also fires.

Software may write a new setting at any time. The setting is held in a shadow register. It becomes active only on the cycle that follows a pulse of the slowest output. At that point the whole set is swapped at once and the phase counter restarts. No output ever sees a shortened period or a mix of the old and new ratios.

Top module: `clk_prescale`

## Requirements
- R1: After reset is released, all three stages divide by 1. `tick_a`, `tick_b` and `tick_c` are high on every cycle, starting with the first cycle after release.
- R2: `tick_a` pulses once every 2^a input cycles, where a is the value of `wr_a_log2`. Values above 9 act as 9.
- R3: `tick_b` pulses once every 2^(a+b) cycles, where b is the value of `wr_b_log2` (0, 1 or 2). The value 3 acts as 2.
- R4: `tick_c` pulses once every 2^(a+b+c) cycles, where c is the value of `wr_c_log2` (0 or 1). The total exponent never exceeds 11. When a+b+c would be 12, the third stage passes its input through (c acts as 0).
- R5: Every `tick_c` pulse coincides with a `tick_b` pulse, and every `tick_b` pulse coincides with a `tick_a` pulse.
- R6: A write while `wr_en` is high changes no output until the first `tick_c` pulse after the write cycle. Up to and including that pulse, all three outputs keep the spacing of the old setting.
- R7: The newly active setting counts its first period from the boundary pulse. The next `tick_c` comes exactly 2^(a+b+c) cycles later, with no shortened or intermediate period.
- R8: When several writes occur before a boundary, only the last one is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock that all pulses are counted in |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Loads the three fields below into the shadow setting |
| wr_a_log2 | input | 4 | First-stage divide exponent (0 to 9) |
| wr_b_log2 | input | 2 | Second-stage divide exponent (0 to 2) |
| wr_c_log2 | input | 1 | Third-stage divide exponent (0 or 1) |
| tick_a | output | 1 | One-cycle enable at the first-stage rate |
| tick_b | output | 1 | One-cycle enable at the second-stage rate |
| tick_c | output | 1 | One-cycle enable at the slowest rate; marks the setting boundary |

## Verification
The assertions assume that reset is held low for at least one edge before normal operation, so that the phase counter and the period monitor start from a known state. They also assume that the write fields are sampled only when `wr_en` is high.

The stimulus always drives the write fields together with `wr_en` on the falling edge, and holds `wr_en` for exactly one cycle per write. It deliberately uses out-of-range field values to reach the clamping behaviour. All of these are legal inputs, so the assumptions hold.

// File: rtl/presc_pkg.sv
package presc_pkg;

  localparam int unsigned N_STAGES = 3;

  // Limit an exponent to a ceiling.
  function automatic int unsigned exp_clamp(input int unsigned v, input int unsigned lim);
    return (v > lim) ? lim : v;
  endfunction

  // Exponent budget still free once `used` has been spent.
  function automatic int unsigned exp_room(input int unsigned used, input int unsigned total);
    return (used >= total) ? 0 : total - used;
  endfunction

endpackage

// File: rtl/presc_cfg.sv
module presc_cfg
  import presc_pkg::*;
#(
  parameter int unsigned A_W       = 4,
  parameter int unsigned B_W       = 2,
  parameter int unsigned C_W       = 1,
  parameter int unsigned EXP_W     = 4,
  parameter int unsigned A_MAX     = 9,
  parameter int unsigned B_MAX     = 2,
  parameter int unsigned C_MAX     = 1,
  parameter int unsigned TOTAL_MAX = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [A_W-1:0]   wr_a,
  input  logic [B_W-1:0]   wr_b,
  input  logic [C_W-1:0]   wr_c,
  input  logic             load,
  output logic [EXP_W-1:0] sh_a,
  output logic [EXP_W-1:0] sh_b,
  output logic [EXP_W-1:0] sh_c,
  output logic [EXP_W-1:0] act_a,
  output logic [EXP_W-1:0] act_b,
  output logic [EXP_W-1:0] act_c
);

  int unsigned ea_w, eb_w, ec_w;

  // Clamp each field in stage order; later stages get what budget remains.
  always_comb begin
    ea_w = exp_clamp(32'(wr_a), exp_clamp(A_MAX, TOTAL_MAX));
    eb_w = exp_clamp(32'(wr_b), exp_clamp(B_MAX, exp_room(ea_w, TOTAL_MAX)));
    ec_w = exp_clamp(32'(wr_c), exp_clamp(C_MAX, exp_room(ea_w + eb_w, TOTAL_MAX)));
  end

  // Shadow setting: written by software at any time.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_a <= '0;
      sh_b <= '0;
      sh_c <= '0;
    end else if (wr_en) begin
      sh_a <= EXP_W'(ea_w);
      sh_b <= EXP_W'(eb_w);
      sh_c <= EXP_W'(ec_w);
    end
  end

  // Active setting: swapped as one unit on the slow-boundary cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_a <= '0;
      act_b <= '0;
      act_c <= '0;
    end else if (load) begin
      act_a <= sh_a;
      act_b <= sh_b;
      act_c <= sh_c;
    end
  end

endmodule

// File: rtl/presc_phase_cnt.sv
module presc_phase_cnt #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt
);

  // Zero marks a common boundary. Restarting at one makes the next
  // boundary land a full new period after the current one.
  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (restart)
      cnt <= CNT_W'(1);
    else
      cnt <= cnt + CNT_W'(1);
  end

endmodule

// File: rtl/presc_tick_dec.sv
module presc_tick_dec #(
  parameter int unsigned CNT_W = 11,
  parameter int unsigned EXP_W = 4
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [EXP_W-1:0] cum_exp,
  output logic             tick
);

  logic [CNT_W-1:0] low_mask;

  // Low `cum_exp` bits set; a shift of CNT_W or more gives all ones.
  assign low_mask = ~({CNT_W{1'b1}} << cum_exp);
  assign tick     = ((cnt & low_mask) == '0);

endmodule

// File: rtl/clk_prescale.sv
module clk_prescale
  import presc_pkg::*;
#(
  parameter int unsigned A_MAX_EXP     = 9,
  parameter int unsigned B_MAX_EXP     = 2,
  parameter int unsigned C_MAX_EXP     = 1,
  parameter int unsigned TOTAL_MAX_EXP = 11,
  localparam int unsigned A_W   = $clog2(A_MAX_EXP + 1),
  localparam int unsigned B_W   = $clog2(B_MAX_EXP + 1),
  localparam int unsigned C_W   = $clog2(C_MAX_EXP + 1),
  localparam int unsigned CNT_W = TOTAL_MAX_EXP,
  localparam int unsigned EXP_W = $clog2(TOTAL_MAX_EXP + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [A_W-1:0] wr_a_log2,
  input  logic [B_W-1:0] wr_b_log2,
  input  logic [C_W-1:0] wr_c_log2,
  output logic           tick_a,
  output logic           tick_b,
  output logic           tick_c
);

  logic [EXP_W-1:0]    sh_a, sh_b, sh_c;
  logic [EXP_W-1:0]    act_a, act_b, act_c;
  logic [EXP_W-1:0]    cum_exp [N_STAGES];
  logic [N_STAGES-1:0] tick_v;
  logic [CNT_W-1:0]    phase;
  logic                boundary;   // slowest output fires: swap point

  presc_cfg #(
    .A_W(A_W), .B_W(B_W), .C_W(C_W), .EXP_W(EXP_W),
    .A_MAX(A_MAX_EXP), .B_MAX(B_MAX_EXP), .C_MAX(C_MAX_EXP),
    .TOTAL_MAX(TOTAL_MAX_EXP)
  ) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .wr_a  (wr_a_log2),
    .wr_b  (wr_b_log2),
    .wr_c  (wr_c_log2),
    .load  (boundary),
    .sh_a  (sh_a),
    .sh_b  (sh_b),
    .sh_c  (sh_c),
    .act_a (act_a),
    .act_b (act_b),
    .act_c (act_c)
  );

  presc_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (boundary),
    .cnt     (phase)
  );

  // Cascade: each stage's exponent accumulates onto the previous one.
  assign cum_exp[0] = act_a;
  assign cum_exp[1] = act_a + act_b;
  assign cum_exp[2] = act_a + act_b + act_c;

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    presc_tick_dec #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_dec (
      .cnt     (phase),
      .cum_exp (cum_exp[s]),
      .tick    (tick_v[s])
    );
  end

  assign boundary = tick_v[N_STAGES-1];
  assign tick_a   = tick_v[0];
  assign tick_b   = tick_v[1];
  assign tick_c   = tick_v[2];

endmodule

// File: rtl/presc_checker.sv
module presc_checker #(
  parameter int unsigned CNT_W     = 11,
  parameter int unsigned EXP_W     = 4,
  parameter int unsigned TOTAL_MAX = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_a,
  input logic             tick_b,
  input logic             tick_c,
  input logic [EXP_W-1:0] sh_a,
  input logic [EXP_W-1:0] sh_b,
  input logic [EXP_W-1:0] sh_c,
  input logic [EXP_W-1:0] act_a,
  input logic [EXP_W-1:0] act_b,
  input logic [EXP_W-1:0] act_c
);

  logic [EXP_W+1:0] act_tot;
  logic [CNT_W:0]   since;
  logic             seen;

  assign act_tot = (EXP_W+2)'(act_a) + (EXP_W+2)'(act_b) + (EXP_W+2)'(act_c);

  // Cycles elapsed since the last slow pulse, counted independently.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since <= (CNT_W+1)'(1);
      seen  <= 1'b0;
    end else if (tick_c) begin
      since <= (CNT_W+1)'(1);
      seen  <= 1'b1;
    end else begin
      since <= since + (CNT_W+1)'(1);
    end
  end

  AST_B_ON_A: assert property (@(posedge clk) disable iff (!rst_n)
    tick_b |-> tick_a);                                               // R5
  AST_C_ON_B: assert property (@(posedge clk) disable iff (!rst_n)
    tick_c |-> tick_b);                                               // R5
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_c |=> ($stable(act_a) && $stable(act_b) && $stable(act_c))); // R6
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tick_c |=> (act_a == $past(sh_a) && act_b == $past(sh_b) && act_c == $past(sh_c))); // R8
  AST_TOTAL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    act_tot <= (EXP_W+2)'(TOTAL_MAX));                                // R4
  AST_SLOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_c && seen) |-> (since == ((CNT_W+1)'(1) << act_tot)));      // R7

endmodule

bind clk_prescale presc_checker #(
  .CNT_W(CNT_W), .EXP_W(EXP_W), .TOTAL_MAX(TOTAL_MAX_EXP)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick_a (tick_a),
  .tick_b (tick_b),
  .tick_c (tick_c),
  .sh_a   (sh_a),
  .sh_b   (sh_b),
  .sh_c   (sh_c),
  .act_a  (act_a),
  .act_b  (act_b),
  .act_c  (act_c)
);

// File: tb/sim_clk_prescale.sv
module sim_clk_prescale;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wa = '0;
  logic [1:0] wb = '0;
  logic [0:0] wc = '0;
  logic       tick_a, tick_b, tick_c;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  clk_prescale u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_a_log2 (wa),
    .wr_b_log2 (wb),
    .wr_c_log2 (wc),
    .tick_a    (tick_a),
    .tick_b    (tick_b),
    .tick_c    (tick_c)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected exponents, restated from the requirements.
  function automatic int ea_of(input int a);
    return (a > 9) ? 9 : a;
  endfunction
  function automatic int eb_of(input int b);
    return (b > 2) ? 2 : b;
  endfunction
  function automatic int ec_of(input int a, input int b, input int c);
    return (ea_of(a) + eb_of(b) + c > 11) ? 0 : c;
  endfunction

  task automatic write_cfg(input int a, input int b, input int c);
    @(negedge clk);
    wr_en = 1'b1; wa = 4'(a); wb = 2'(b); wc = 1'(c);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_c();
    int guard = 0;
    while (!tick_c && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // Starts on a boundary cycle; runs one full slow period and checks it.
  task automatic measure(input int a, input int b, input int c, output int n);
    int ea = ea_of(a);
    int eb = eb_of(b);
    int ec = ec_of(a, b, c);
    int pa = 1 << ea;
    int pb = 1 << (ea + eb);
    int pc = 1 << (ea + eb + ec);
    int na = 0, nb = 0, fa = 0, fb = 0;
    bit aligned = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (tick_a) begin na++; if (fa == 0) fa = n; end
      if (tick_b) begin nb++; if (fb == 0) fb = n; end
      if (tick_b && !tick_a) aligned = 1'b0;
    end while (!tick_c && n < 5000);
    if (!(tick_a && tick_b)) aligned = 1'b0;
    chk(n == pc, "R4 R7", "slow period", n, pc);
    chk(fa == pa, "R2", "first tick_a spacing", fa, pa);
    chk(na == pc / pa, "R2", "tick_a per slow period", na, pc / pa);
    chk(fb == pb, "R3", "first tick_b spacing", fb, pb);
    chk(nb == pc / pb, "R3", "tick_b per slow period", nb, pc / pb);
    chk(aligned, "R5", "pulses nested in phase", int'(aligned), 1);
  endtask

  task automatic t_reset();
    int ones = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (tick_a && tick_b && tick_c) ones++;
      @(negedge clk);
    end
    chk(ones == 4, "R1", "all ticks every cycle after reset", ones, 4);
  endtask

  task automatic t_ratio(input int a, input int b, input int c);
    int n;
    write_cfg(a, b, c);
    wait_c();
    measure(a, b, c, n);
  endtask

  task automatic t_hold();
    int n = 0, na = 0, m;
    write_cfg(5, 0, 0);
    wait_c();
    measure(5, 0, 0, m);
    // Mid-period write of divide-by-1 must not disturb the running period.
    do begin
      @(negedge clk);
      n++;
      if (n == 4) begin wr_en = 1'b1; wa = '0; wb = '0; wc = '0; end
      else wr_en = 1'b0;
      if (tick_a && !tick_c) na++;
    end while (!tick_c && n < 5000);
    chk(n == 32, "R6", "old period completes after write", n, 32);
    chk(na == 0, "R6", "no early tick_a after write", na, 0);
    @(negedge clk);
    chk(tick_c == 1'b1, "R7", "new divide-by-1 right after boundary", int'(tick_c), 1);
  endtask

  task automatic t_last_wins();
    int n;
    write_cfg(6, 0, 0);
    wait_c();
    measure(6, 0, 0, n);
    write_cfg(1, 0, 0);
    write_cfg(3, 0, 0);
    wait_c();
    measure(3, 0, 0, n);
    chk(n == 8, "R8", "last write applied", n, 8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R7 watchdog: actual hung expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_ratio(0, 0, 0);
    t_ratio(3, 0, 0);
    t_ratio(9, 0, 0);
    t_ratio(2, 1, 0);
    t_ratio(1, 2, 1);
    t_ratio(0, 0, 1);
    t_ratio(4, 1, 1);
    t_ratio(15, 3, 0);   // R2 R3 clamping of out-of-range fields
    t_ratio(9, 2, 1);    // R4 cap at 2048, third stage passes through
    t_hold();
    t_last_wins();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule